// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block is a single-master I2C engine driven by simple command inputs. A `go` pulse opens a transaction: the block forms a START, sends the slave address with the direction bit in either 7-bit or 10-bit form, then parks with SCL held low. While parked it waits for the next request. A write request hands it a byte to send. A read request asks for one byte and says whether that byte is the last. A restart request issues a repeated START and resends the address with a fresh direction bit. A stop request closes the bus. Both bus lines are open-drain, and each output is a pull-low enable.

The bit timing comes from one of four tick inputs, picked by `clk_sel`. A prescaler then counts those ticks. Each bit is split into four equal quarters of `div/4` ticks, rounded down. SCL is low in the first two quarters and high in the last two. SDA moves at the start of the second quarter and is sampled at the end of the third. A slave that refuses an address or data byte ends the transaction: the block raises a sticky NACK flag and generates a STOP.

Top module: `i2c_seq_master`

## Requirements
- R1: After reset the block is idle: `busy`, `nack`, `done` are 0 and neither line is pulled. A `go` while idle produces a START (SDA falls while SCL is high). `busy` stays 1 until the STOP completes, and `done` pulses for one cycle as `busy` falls.
- R2: Each byte takes exactly nine SCL pulses: eight data bits MSB first, then one acknowledge slot. A write byte is taken, and `take` pulses, only in response to `wr_req` or `rd_req`.
- R3: While SCL is high, SDA changes only to form a START or a STOP.
- R4: In 7-bit mode the first byte after START is `{addr[6:0], rw}`. `rw`=0 means master writes and `rw`=1 means master reads.
- R5: In 10-bit mode the first byte is `{5'b11110, addr[9:8], rw}` and the second byte is `addr[7:0]`, each followed by an acknowledge slot. After a repeated START with `rw`=1, only the first byte is sent.
- R6: A held `restart_req` at a byte boundary issues a repeated START with no STOP before it. The address is then resent with the new direction bit.
- R7: In read mode the block drives ACK (SDA low) after every requested byte except one marked `rd_last`. For that byte it leaves SDA high (NACK) and then generates a STOP. Each received byte appears on `rd_data`, assembled MSB first, with a one-cycle `rd_valid`.
- R8: A NACK from the slave on an address or write byte sets `nack`, and the block generates a STOP without sending further bytes. `nack` holds until the next accepted `go`.
- R9: Only the tick input chosen by `clk_sel` advances the bus. One bit lasts 4*floor(`div`/4) ticks of that input.
- R10: A `div` below 4 behaves as 4, so each SCL phase lasts at least two ticks.
- R11: A `go` pulse while `busy` is 1 has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | NSRC | Candidate tick enables for the bit clock |
| clk_sel | input | SELW | Selects one of `tick_src` |
| div | input | DIVW | Ticks per bit; values under 4 act as 4 |
| go | input | 1 | Begin a transaction (idle only) |
| rw | input | 1 | Direction bit for START or restart: 1 = read |
| ten | input | 1 | 1 = 10-bit addressing |
| addr | input | 10 | Slave address (7-bit mode uses bits 6:0) |
| stop_req | input | 1 | Finish with STOP at the next byte boundary |
| restart_req | input | 1 | Repeated START at the next byte boundary |
| wr_req | input | 1 | Send `wr_data` as the next byte (write mode) |
| wr_data | input | 8 | Byte to transmit |
| take | output | 1 | One-cycle pulse: a write or read request was accepted |
| rd_req | input | 1 | Receive one more byte (read mode) |
| rd_last | input | 1 | The requested byte is the last one; NACK it |
| rd_data | output | 8 | Last received byte |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` updated |
| busy | output | 1 | Transaction in progress, START through STOP |
| nack | output | 1 | Sticky flag: slave refused a byte |
| done | output | 1 | One-cycle pulse when the STOP completes |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The bound checker watches several rules on every cycle. The master never moves SDA under a high SCL outside START and STOP. Both lines are released whenever the block is idle. `done` coincides with the fall of `busy`, and a NACK always leads into STOP. `take` only answers a pending request. Other properties are visible only at the bus: byte contents, bit order, the 10-bit prefix and the omitted second address byte, ACK versus NACK on the last read, and the restart without an intervening STOP. The measured SCL period under each source and divider is also a bus-level result. These are shown by the bench, whose behavioural slave decodes the bus and answers it.

// File: rtl/i2c_seq_master.sv
module i2c_seq_master #(
  parameter int DIVW = 8,
  parameter int NSRC = 4,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_src,
  input  logic [SELW-1:0] clk_sel,
  input  logic [DIVW-1:0] div,
  input  logic            go,
  input  logic            rw,
  input  logic            ten,
  input  logic [9:0]      addr,
  input  logic            stop_req,
  input  logic            restart_req,
  input  logic            wr_req,
  input  logic [7:0]      wr_data,
  output logic            take,
  input  logic            rd_req,
  input  logic            rd_last,
  output logic [7:0]      rd_data,
  output logic            rd_valid,
  output logic            busy,
  output logic            nack,
  output logic            done,
  output logic            scl_oe,
  output logic            sda_oe,
  input  logic            sda_in
);
  typedef enum logic [2:0] {IDLE, START, BITS, HOLD, STOP} st_t;
  localparam logic [1:0] A1 = 2'd0, A2 = 2'd1, DT = 2'd2;

  st_t             st;
  logic [1:0]      ph, stg;
  logic [3:0]      bi;
  logic [7:0]      sh;
  logic [9:0]      ad;
  logic [DIVW-1:0] qc;
  logic            samp, sda_hold, rs, rd, tn, rlast;

  wire [DIVW-1:0] deff   = (div < DIVW'(4)) ? DIVW'(4) : div;
  wire [DIVW-1:0] qlen   = deff >> 2;
  wire            tick   = tick_src[clk_sel];
  wire            qend   = tick && (qc == qlen - DIVW'(1));
  wire            xmit   = (stg != DT) || !rd;
  wire            bitdrv = (bi != 4'd8) ? (xmit && !sh[7]) : (!xmit && !rlast);

  assign busy = (st != IDLE);

  always_comb begin
    case (st)
      START:   begin scl_oe = (ph == 2'd0) && rs; sda_oe = ph[1]; end
      BITS:    begin scl_oe = !ph[1]; sda_oe = (ph == 2'd0) ? sda_hold : bitdrv; end
      HOLD:    begin scl_oe = 1'b1;   sda_oe = sda_hold; end
      STOP:    begin scl_oe = !ph[1]; sda_oe = (ph == 2'd0) ? sda_hold : (ph != 2'd3); end
      default: begin scl_oe = 1'b0;   sda_oe = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ph <= '0; stg <= A1; bi <= '0; sh <= '0; ad <= '0; qc <= '0;
      samp <= 1'b0; sda_hold <= 1'b0; rs <= 1'b0; rd <= 1'b0; tn <= 1'b0; rlast <= 1'b0;
      rd_data <= '0; rd_valid <= 1'b0; take <= 1'b0; nack <= 1'b0; done <= 1'b0;
    end else begin
      take <= 1'b0; rd_valid <= 1'b0; done <= 1'b0;
      if (st == IDLE || st == HOLD) qc <= '0;
      else if (tick) qc <= qend ? '0 : qc + DIVW'(1);
      case (st)
        IDLE: if (go) begin
          st <= START; ph <= '0; rs <= 1'b0; rd <= rw; tn <= ten; ad <= addr; nack <= 1'b0;
        end
        HOLD: begin
          ph <= '0; bi <= '0;
          if (stop_req) st <= STOP;
          else if (restart_req) begin
            st <= START; rs <= 1'b1; rd <= rw; tn <= ten; ad <= addr;
          end else if (!rd && wr_req) begin
            st <= BITS; sh <= wr_data; take <= 1'b1;
          end else if (rd && rd_req) begin
            st <= BITS; rlast <= rd_last; take <= 1'b1;
          end
        end
        default: if (qend) begin
          ph <= ph + 2'd1;
          if (ph == 2'd2) samp <= sda_in;
          if (ph == 2'd3) begin
            case (st)
              START: begin
                st <= BITS; sda_hold <= 1'b1; bi <= '0; stg <= A1;
                sh <= tn ? {5'b11110, ad[9:8], rd} : {ad[6:0], rd};
              end
              STOP: begin st <= IDLE; done <= 1'b1; end
              default: begin
                sda_hold <= bitdrv;
                sh <= {sh[6:0], samp};
                if (bi != 4'd8) bi <= bi + 4'd1;
                else begin
                  bi <= '0;
                  if (!xmit) begin
                    rd_data <= sh; rd_valid <= 1'b1;
                    st <= rlast ? STOP : HOLD;
                  end else if (samp) begin
                    nack <= 1'b1; st <= STOP;
                  end else if (stg == A1 && tn && !(rs && rd)) begin
                    stg <= A2; sh <= ad[7:0];
                  end else begin
                    stg <= DT; st <= HOLD;
                  end
                end
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

module i2c_seq_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic       done,
  input logic       nack,
  input logic       take,
  input logic       wr_req,
  input logic       rd_req
);
  // R3
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (st == 3'd1 || st == 3'd4));
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));
  // R1
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack) |-> (st == 3'd4));
  // R2
  take_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(wr_req || rd_req));
endmodule

bind i2c_seq_master i2c_seq_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(busy), .done(done), .nack(nack), .take(take), .wr_req(wr_req), .rd_req(rd_req)
);

// File: tb/i2c_seq_master_test.sv
module i2c_seq_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic tk1 = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic [7:0] div = 8'd8, wr_data = 8'd0;
  logic go = 0, rw = 0, ten = 0, stop_req = 0, restart_req = 0, wr_req = 0, rd_req = 0, rd_last = 0;
  logic [9:0] addr = 10'd0;
  wire take, rd_valid, busy, nack, done, scl_oe, sda_oe;
  wire [7:0] rd_data;
  logic s_pull = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || s_pull);
  wire [3:0] tick_src = {1'b1, 1'b0, tk1, 1'b1};

  i2c_seq_master uut (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .clk_sel(clk_sel), .div(div),
    .go(go), .rw(rw), .ten(ten), .addr(addr), .stop_req(stop_req), .restart_req(restart_req),
    .wr_req(wr_req), .wr_data(wr_data), .take(take), .rd_req(rd_req), .rd_last(rd_last),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .nack(nack), .done(done),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line));

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (done) done_cnt++;
  initial forever begin @(negedge clk); tk1 = ~tk1; end

  logic [7:0] mb [0:15];
  logic       ma [0:15];
  logic [7:0] msh = 8'd0;
  logic       s_read = 1'b0;
  int nb = 0, mbit = 0, bidx = 0, nstart = 0, nstop = 0, snap = 0, rise_prev = 0, per = 0, nack_idx = -1;

  always @(negedge sda_line) if (scl_line) begin
    nstart++; snap = nstop; mbit = 0; bidx = 0; s_read = 1'b0; s_pull = 1'b0;
  end
  always @(posedge sda_line) if (scl_line) nstop++;
  always @(posedge scl_line) begin
    if (mbit < 8) begin msh = {msh[6:0], sda_line}; mbit++; end
    else begin
      per = cyc - rise_prev;
      if (nb < 16) begin mb[nb] = msh; ma[nb] = sda_line; end
      nb++;
      if (bidx == 0 && msh[0] && !sda_line) s_read = 1'b1;
      else if (s_read && sda_line) s_read = 1'b0;
      bidx++; mbit = 0;
    end
    rise_prev = cyc;
  end
  always @(negedge scl_line) begin
    logic [7:0] v;
    v = 8'hA5 ^ 8'(bidx);
    if (s_read) s_pull = (mbit < 8) && !v[7 - mbit];
    else s_pull = (mbit == 8) && (bidx != nack_idx);
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nb = 0; nstart = 0; nstop = 0; snap = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic begin_tx(logic t, logic [9:0] a, logic r);
    int n0;
    n0 = nstart;
    ten = t; addr = a; rw = r; go = 1'b1;
    @(negedge clk); go = 1'b0;
    do @(negedge clk); while (nstart == n0);
  endtask

  task automatic wbyte(logic [7:0] d);
    wr_data = d; wr_req = 1'b1;
    do @(negedge clk); while (!take);
    wr_req = 1'b0;
  endtask

  task automatic rbyte(logic last, output logic [7:0] got);
    rd_req = 1'b1; rd_last = last;
    do @(negedge clk); while (!take);
    rd_req = 1'b0;
    do @(negedge clk); while (!rd_valid);
    got = rd_data;
  endtask

  task automatic finish_stop();
    stop_req = 1'b1; wait_idle(); stop_req = 1'b0;
  endtask

  task automatic do_restart(logic t, logic [9:0] a, logic r);
    int n0;
    n0 = nstart;
    ten = t; addr = a; rw = r; restart_req = 1'b1;
    do @(negedge clk); while (nstart == n0);
    restart_req = 1'b0;
  endtask

  typedef struct packed {
    logic       t;
    logic [9:0] a;
    logic [7:0] d;
    logic [7:0] dv;
    logic [1:0] sel;
    logic [7:0] e0, e1, e2;
    logic [1:0] n;
    logic [7:0] per;
  } vec_t;
  localparam vec_t VEC [4] = '{
    '{1'b0, 10'h050, 8'h3C, 8'd8,  2'd0, 8'hA0, 8'h3C, 8'h00, 2'd2, 8'd8},
    '{1'b0, 10'h07F, 8'hC3, 8'd2,  2'd0, 8'hFE, 8'hC3, 8'h00, 2'd2, 8'd4},
    '{1'b1, 10'h2A5, 8'h81, 8'd4,  2'd1, 8'hF4, 8'hA5, 8'h81, 2'd3, 8'd8},
    '{1'b1, 10'h13C, 8'h55, 8'd13, 2'd3, 8'hF2, 8'h3C, 8'h55, 2'd3, 8'd12}
  };

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog (R1 R2): run incomplete, got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] g;
    int d0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 busy at reset", busy, 0);
    check("R1 nack at reset", nack, 0);
    check("R1 lines released", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done idle", done, 0);

    // R2 R4 R5 R9 R10 table walk
    foreach (VEC[i]) begin
      logic [7:0] ex [3];
      ex = '{VEC[i].e0, VEC[i].e1, VEC[i].e2};
      clear_mon(); d0 = done_cnt;
      div = VEC[i].dv; clk_sel = VEC[i].sel;
      begin_tx(VEC[i].t, VEC[i].a, 1'b0);
      wbyte(VEC[i].d);
      finish_stop();
      @(negedge clk);
      check("R2 byte count", nb, int'(VEC[i].n));
      for (int k = 0; k < int'(VEC[i].n); k++) begin
        check(VEC[i].t ? "R5 10-bit byte" : "R4 7-bit byte", mb[k], ex[k]);
        check("R2 slave ack", ma[k], 0);
      end
      check("R9 R10 bit period", per, int'(VEC[i].per));
      check("R3 one START", nstart, 1);
      check("R3 one STOP", nstop, 1);
      check("R1 done pulse", done_cnt - d0, 1);
    end
    div = 8'd8; clk_sel = 2'd0;

    // R7 read with final NACK
    clear_mon();
    begin_tx(1'b0, 10'h021, 1'b1);
    rbyte(1'b0, g); check("R7 read byte 1", g, 8'hA4);
    rbyte(1'b0, g); check("R7 read byte 2", g, 8'hA7);
    rbyte(1'b1, g); check("R7 read byte 3", g, 8'hA6);
    wait_idle();
    check("R4 read address", mb[0], 8'h43);
    check("R7 ack byte 1", ma[1], 0);
    check("R7 ack byte 2", ma[2], 0);
    check("R7 nack last", ma[3], 1);
    check("R7 stop after last", nstop, 1);

    // R6 repeated START write then read
    clear_mon();
    begin_tx(1'b0, 10'h033, 1'b0);
    wbyte(8'h99);
    do_restart(1'b0, 10'h033, 1'b1);
    rbyte(1'b1, g);
    wait_idle();
    check("R6 read after restart", g, 8'hA4);
    check("R6 two STARTs", nstart, 2);
    check("R6 no STOP before restart", snap, 0);
    check("R6 first address", mb[0], 8'h66);
    check("R6 data", mb[1], 8'h99);
    check("R6 new direction", mb[2], 8'h67);

    // R5 10-bit read via restart
    clear_mon();
    begin_tx(1'b1, 10'h2A5, 1'b0);
    do_restart(1'b1, 10'h2A5, 1'b1);
    rbyte(1'b1, g);
    wait_idle();
    check("R5 byte count", nb, 4);
    check("R5 prefix read", mb[2], 8'hF5);
    check("R5 read data", g, 8'hA4);

    // R8 address NACK
    clear_mon(); nack_idx = 0;
    begin_tx(1'b0, 10'h011, 1'b0);
    wait_idle();
    check("R8 nack flag addr", nack, 1);
    check("R8 bytes after addr nack", nb, 1);
    check("R8 stop after addr nack", nstop, 1);
    repeat (5) @(negedge clk);
    check("R8 nack sticky", nack, 1);

    // R8 data NACK
    clear_mon(); nack_idx = 1;
    begin_tx(1'b0, 10'h012, 1'b0);
    check("R8 nack cleared by go", nack, 0);
    wbyte(8'h5A);
    wait_idle();
    check("R8 nack flag data", nack, 1);
    check("R8 bytes after data nack", nb, 2);
    check("R8 stop after data nack", nstop, 1);
    nack_idx = -1;

    // R11 go while busy
    clear_mon();
    begin_tx(1'b0, 10'h044, 1'b0);
    ten = 1'b0; addr = 10'h010; rw = 1'b1; go = 1'b1;
    @(negedge clk); go = 1'b0;
    wbyte(8'h11);
    finish_stop();
    check("R11 single START", nstart, 1);
    check("R11 address kept", mb[0], 8'h88);
    check("R11 byte count", nb, 2);

    // R9 unselected source does not advance
    clear_mon(); clk_sel = 2'd2;
    ten = 1'b0; addr = 10'h055; rw = 1'b0; go = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (40) @(negedge clk);
    check("R9 stalled without ticks", nstart, 0);
    check("R9 bus untouched", {scl_line, sda_line}, 2'b11);
    clk_sel = 2'd0;
    finish_stop();
    check("R9 resumes on selected source", mb[0], 8'hAA);
    check("R9 stop after resume", nstop, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule